// File: doc/BRIEF.md
# Secured Configuration Access Controller

This block sits between a host and the configuration storage of a programmable logic array. The host issues one command at a time on a small command bus: an opcode, an address and a write word. The block writes and reads back fuse words, forces the macrocell registers to chosen values for test, reads and writes an eight-byte user signature, and sets a one-time lock. The fuse words and the signature live in register arrays inside the block. The macrocell register values are driven out on their own port.

A command is taken on a clock edge when `cmd_valid` is high and `busy` is low. It runs in the following cycle, while `busy` is high. Its result shows in the cycle after that, as a one-cycle `done` pulse with `rd_data` and `err`. Once the lock is set, fuse read-back and register preload are refused. The user signature stays readable and writable. Only a full erase removes the lock.

Top module: `cfg_access_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `rd_data` and `mc_state` are all zero, every fuse word is zero, every signature byte reads 8'hFF and the lock is clear.
- R2: A command presented with `busy` low is taken at that clock edge. `busy` is high for exactly the next cycle, and `done` is high for exactly one cycle after that. `rd_data` and `err` are valid only while `done` is high; `rd_data` is zero otherwise.
- R3: A command presented while `busy` is high is ignored and changes no state.
- R4: Opcode 3'd0 writes `cmd_wdata` to fuse word `cmd_addr`, whether or not the lock is set. Opcode 3'd1, when unlocked, returns fuse word `cmd_addr` on `rd_data` with `err` low.
- R5: Opcode 3'd2, when unlocked, loads `mc_state` from `cmd_wdata[9:0]`, bit i to register i, each bit set to 1 or 0 on its own.
- R6: Opcode 3'd4 writes `cmd_wdata[7:0]` to signature byte `cmd_addr[2:0]`. Opcode 3'd3 returns that byte on `rd_data[7:0]`, with the upper bits zero. The eight bytes are independent.
- R7: Opcode 3'd5 sets the lock. The lock applies to the very next command.
- R8: A fuse read-back while locked returns all-zero `rd_data` and raises `err` for the `done` cycle.
- R9: A preload while locked leaves `mc_state` unchanged and raises `err`.
- R10: Signature reads and writes work the same with the lock set as without it.
- R11: Opcode 3'd6 clears every fuse word to zero, sets every signature byte to 8'hFF and clears the lock.
- R12: Opcode 3'd7 is undefined. It raises `err` and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Opcode |
| cmd_addr | input | ADDR_W (5) | Fuse word index, or signature byte index in the low 3 bits |
| cmd_wdata | input | DW (16) | Write word |
| busy | output | 1 | Command executing; new commands are ignored |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Command refused or undefined; valid with done |
| rd_data | output | DW (16) | Read result; valid with done |
| mc_state | output | NREG (10) | Macrocell register values |

## Verification
The assertions check the timing on every cycle: `busy` lasts one cycle, `done` follows it and lasts one cycle, and `err` appears only with `done`. They also check that the lock stays set until an erase, that an erase clears it, and that a refused read-back or preload returns zero data or holds `mc_state`. Some properties need the stored contents, so only the bench scenarios can show them. These are the values read back after writes, the independence of the signature bytes, the erase restoring fuses and signature, and the effect of a command ignored while `busy` was high.

// File: rtl/cfg_acc_pkg.sv
package cfg_acc_pkg;
  typedef enum logic [2:0] {
    OP_FUSE_WR  = 3'd0,
    OP_FUSE_VFY = 3'd1,
    OP_PRELOAD  = 3'd2,
    OP_SIG_RD   = 3'd3,
    OP_SIG_WR   = 3'd4,
    OP_SECURE   = 3'd5,
    OP_ERASE    = 3'd6,
    OP_RSVD     = 3'd7
  } op_e;
endpackage

// File: rtl/cfg_cmd_stage.sv
module cfg_cmd_stage #(
  parameter int ADDR_W = 5,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DW-1:0]     cmd_wdata,
  output logic              busy,
  output logic [2:0]        ex_op,
  output logic [ADDR_W-1:0] ex_addr,
  output logic [DW-1:0]     ex_wdata
);
  logic accept;
  logic busy_q, busy_d;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     wdata_q;

  // A command is taken only when the stage is idle.
  always_comb begin
    accept = cmd_valid & ~busy_q;
    busy_d = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      op_q    <= cmd_op;
      addr_q  <= cmd_addr;
      wdata_q <= cmd_wdata;
    end
  end

  assign busy     = busy_q;
  assign ex_op    = op_q;
  assign ex_addr  = addr_q;
  assign ex_wdata = wdata_q;
endmodule

// File: rtl/cfg_word_bank.sv
module cfg_word_bank #(
  parameter int           AW   = 5,
  parameter int           W    = 16,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          restore,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] word_flat [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [W-1:0] q, d;
    logic         en;

    // Restore to INIT takes precedence over a single-word write.
    always_comb begin
      en = restore | (wr_en && (addr == AW'(g)));
      d  = restore ? INIT : wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= INIT;
      end else if (en) begin
        q <= d;
      end
    end

    assign word_flat[g] = q;
  end

  assign rdata = word_flat[addr];
endmodule

// File: rtl/cfg_access_ctrl.sv
module cfg_access_ctrl #(
  parameter int FUSE_AW = 5,
  parameter int FUSE_W  = 16,
  parameter int SIG_AW  = 3,
  parameter int NREG    = 10,
  parameter int DW      = 16,
  parameter int ADDR_W  = FUSE_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DW-1:0]     cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DW-1:0]     rd_data,
  output logic [NREG-1:0]   mc_state
);
  import cfg_acc_pkg::*;

  localparam int SIG_W = 8;

  logic [2:0]        ex_op;
  logic [ADDR_W-1:0] ex_addr;
  logic [DW-1:0]     ex_wdata;
  logic              ex_busy;
  op_e               op;

  logic              fuse_wr, fuse_clr;
  logic [FUSE_W-1:0] fuse_rdata;
  logic              sig_wr, sig_set;
  logic [SIG_W-1:0]  sig_rdata;

  logic              sec_q, sec_d;
  logic [NREG-1:0]   mc_q, mc_d;
  logic              mc_en;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic [DW-1:0]     rd_q, rd_d;

  cfg_cmd_stage #(.ADDR_W(ADDR_W), .DW(DW)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .busy      (ex_busy),
    .ex_op     (ex_op),
    .ex_addr   (ex_addr),
    .ex_wdata  (ex_wdata)
  );

  cfg_word_bank #(.AW(FUSE_AW), .W(FUSE_W), .INIT('0)) u_fuse (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fuse_wr),
    .restore (fuse_clr),
    .addr    (ex_addr[FUSE_AW-1:0]),
    .wdata   (ex_wdata[FUSE_W-1:0]),
    .rdata   (fuse_rdata)
  );

  cfg_word_bank #(.AW(SIG_AW), .W(SIG_W), .INIT({SIG_W{1'b1}})) u_sig (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sig_wr),
    .restore (sig_set),
    .addr    (ex_addr[SIG_AW-1:0]),
    .wdata   (ex_wdata[SIG_W-1:0]),
    .rdata   (sig_rdata)
  );

  assign op = op_e'(ex_op);

  // Execute stage: decode the held command against the current lock.
  always_comb begin
    fuse_wr  = 1'b0;
    fuse_clr = 1'b0;
    sig_wr   = 1'b0;
    sig_set  = 1'b0;
    sec_d    = sec_q;
    mc_en    = 1'b0;
    mc_d     = mc_q;
    rd_d     = '0;
    err_d    = 1'b0;
    done_d   = ex_busy;
    if (ex_busy) begin
      case (op)
        OP_FUSE_WR:  fuse_wr = 1'b1;
        OP_FUSE_VFY: begin
          if (sec_q) err_d = 1'b1;
          else       rd_d  = DW'(fuse_rdata);
        end
        OP_PRELOAD: begin
          if (sec_q) begin
            err_d = 1'b1;
          end else begin
            mc_en = 1'b1;
            mc_d  = ex_wdata[NREG-1:0];
          end
        end
        OP_SIG_RD:   rd_d   = DW'(sig_rdata);
        OP_SIG_WR:   sig_wr = 1'b1;
        OP_SECURE:   sec_d  = 1'b1;
        OP_ERASE: begin
          fuse_clr = 1'b1;
          sig_set  = 1'b1;
          sec_d    = 1'b0;
        end
        default:     err_d  = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
      rd_q   <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= 1'b0;
    end else if (ex_busy) begin
      sec_q <= sec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q <= '0;
    end else if (mc_en) begin
      mc_q <= mc_d;
    end
  end

  assign busy     = ex_busy;
  assign done     = done_q;
  assign err      = err_q;
  assign rd_data  = rd_q;
  assign mc_state = mc_q;
endmodule

// File: rtl/cfg_access_ctrl_chk.sv
module cfg_access_ctrl_chk #(
  parameter int DW   = 16,
  parameter int NREG = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic [DW-1:0]   rd_data,
  input logic [NREG-1:0] mc_state,
  input logic [2:0]      ex_op,
  input logic            sec_q
);
  import cfg_acc_pkg::*;

  // R2
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // R2
  done_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> done);

  // R2
  no_done_without_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !done);

  // R2
  err_only_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q && !(busy && ex_op == OP_ERASE)) |=> sec_q);

  // R8
  locked_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ex_op == OP_FUSE_VFY && sec_q) |=> (err && rd_data == '0));

  // R9
  locked_preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ex_op == OP_PRELOAD && sec_q) |=> (err && $stable(mc_state)));

  // R11
  erase_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ex_op == OP_ERASE) |=> !sec_q);

  // R12
  undefined_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ex_op == OP_RSVD) |=> (err && $stable(mc_state) && $stable(sec_q)));
endmodule

bind cfg_access_ctrl cfg_access_ctrl_chk #(.DW(DW), .NREG(NREG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .rd_data  (rd_data),
  .mc_state (mc_state),
  .ex_op    (ex_op),
  .sec_q    (sec_q)
);

// File: tb/tb_cfg_access_ctrl.sv
module tb_cfg_access_ctrl;
  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [4:0]  cmd_addr;
  logic [15:0] cmd_wdata;
  logic        busy, done, err;
  logic [15:0] rd_data;
  logic [9:0]  mc_state;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  cfg_access_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .err(err), .rd_data(rd_data), .mc_state(mc_state)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference state kept from the requirements
  logic [15:0] fuse_m [32];
  logic [7:0]  sig_m  [8];
  bit          sec_m;
  logic [9:0]  mc_m;

  typedef struct {
    logic [15:0] rd;
    logic        er;
    logic [9:0]  mc;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        chk("R2 unexpected done", 32'(done), 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.tag, " rd_data"}, 32'(rd_data), 32'(e.rd));
        chk({e.tag, " err"}, 32'(err), 32'(e.er));
        chk({e.tag, " mc_state"}, 32'(mc_state), 32'(e.mc));
      end
    end
  end

  // Driver: issue one command, update the model and push the expectation.
  task automatic issue(input logic [2:0] op, input logic [4:0] addr,
                       input logic [15:0] wd, input string tag,
                       input bit hold_extra = 0);
    exp_t e;
    e.rd = '0; e.er = 1'b0; e.tag = tag;
    case (op)
      3'd0: fuse_m[addr] = wd;
      3'd1: if (sec_m) e.er = 1'b1; else e.rd = fuse_m[addr];
      3'd2: if (sec_m) e.er = 1'b1; else mc_m = wd[9:0];
      3'd3: e.rd = {8'h00, sig_m[addr[2:0]]};
      3'd4: sig_m[addr[2:0]] = wd[7:0];
      3'd5: sec_m = 1'b1;
      3'd6: begin
        for (int i = 0; i < 32; i++) fuse_m[i] = '0;
        for (int i = 0; i < 8; i++) sig_m[i] = 8'hFF;
        sec_m = 1'b0;
      end
      default: e.er = 1'b1;
    endcase
    e.mc = mc_m;
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_wdata = wd;
    @(negedge clk);
    sb_q.push_back(e);
    chk({tag, " R2 busy after accept"}, 32'(busy), 32'd1);
    chk({tag, " R2 no early done"}, 32'(done), 32'd0);
    if (hold_extra) begin
      // R3: a fuse write presented while busy must be dropped
      cmd_op = 3'd0; cmd_addr = 5'd9; cmd_wdata = 16'hBEEF;
    end else begin
      cmd_valid = 1'b0;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) fuse_m[i] = '0;
    for (int i = 0; i < 8; i++) sig_m[i] = 8'hFF;
    sec_m = 1'b0; mc_m = '0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 rd_data", 32'(rd_data), 0);
    chk("R1 mc_state", 32'(mc_state), 0);
    for (int i = 0; i < 8; i++) issue(3'd3, 5'(i), 16'h0, "R1 signature reset");
    issue(3'd1, 5'd3, 16'h0, "R1 fuse reset");

    // R4 fuse write and read-back
    issue(3'd0, 5'd0, 16'hA5C3, "R4 wr");
    issue(3'd0, 5'd31, 16'h7E01, "R4 wr");
    issue(3'd0, 5'd7, 16'hFFFF, "R4 wr");
    issue(3'd1, 5'd0, 16'h0, "R4 vfy 0");
    issue(3'd1, 5'd31, 16'h0, "R4 vfy 31");
    issue(3'd1, 5'd7, 16'h0, "R4 vfy 7");
    issue(3'd1, 5'd8, 16'h0, "R4 vfy untouched");

    // R5 preload patterns
    issue(3'd2, 5'd0, 16'hF2A5, "R5 preload");
    issue(3'd2, 5'd0, 16'h035A, "R5 preload");
    issue(3'd2, 5'd0, 16'h0201, "R5 preload");

    // R6 signature bytes
    for (int i = 0; i < 8; i++) issue(3'd4, 5'(i), 16'hAB00 | 16'(i * 17 + 3), "R6 sig wr");
    for (int i = 0; i < 8; i++) issue(3'd3, 5'(i), 16'h0, "R6 sig rd");
    issue(3'd3, 5'd13, 16'h0, "R6 sig rd low index bits");

    // R3 command held while busy is dropped
    issue(3'd1, 5'd9, 16'h0, "R3 before", 1'b1);
    issue(3'd1, 5'd9, 16'h0, "R3 fuse 9 untouched");

    // R12 undefined opcode
    issue(3'd7, 5'd0, 16'h03FF, "R12 undefined");
    issue(3'd1, 5'd0, 16'h0, "R12 lock still clear");

    // R7 lock effective on the next command
    issue(3'd5, 5'd0, 16'h0, "R7 secure");
    issue(3'd1, 5'd0, 16'h0, "R8 locked vfy 0");
    issue(3'd1, 5'd31, 16'h0, "R8 locked vfy 31");
    issue(3'd2, 5'd0, 16'h03FF, "R9 locked preload");
    issue(3'd2, 5'd0, 16'h0000, "R9 locked preload");
    issue(3'd0, 5'd4, 16'h1234, "R4 wr while locked");
    issue(3'd1, 5'd4, 16'h0, "R8 locked vfy 4");
    issue(3'd3, 5'd2, 16'h0, "R10 sig rd locked");
    issue(3'd4, 5'd5, 16'h005A, "R10 sig wr locked");
    issue(3'd3, 5'd5, 16'h0, "R10 sig rd locked");
    issue(3'd5, 5'd0, 16'h0, "R7 secure again");

    // R11 erase
    issue(3'd6, 5'd0, 16'h0, "R11 erase");
    issue(3'd1, 5'd0, 16'h0, "R11 fuse 0 cleared");
    issue(3'd1, 5'd4, 16'h0, "R11 fuse 4 cleared");
    issue(3'd3, 5'd5, 16'h0, "R11 sig restored");
    issue(3'd3, 5'd0, 16'h0, "R11 sig restored");
    issue(3'd2, 5'd0, 16'h0155, "R11 preload unlocked");

    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", 32'(sb_q.size()), 0);
    chk("R2 rd_data idle zero", 32'(rd_data), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule